// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block chooses where each operand of an in-order eight-stage integer pipeline takes its value from. The pipeline fetches over two stages and decodes in a third. Execution then runs over two stages, EX1 and EX2. After that come MEM1, where ALU results are also written back, MEM2, and a final write-back stage for loads (LWB). An ALU result exists at the end of EX2, but a load value exists only at the end of MEM2. So the block has to know which class of instruction produced a register, and how far it has travelled, before it can say whether a bypass exists.

The block is purely combinational. It looks at three producer slots: the instructions now in MEM1, MEM2 and LWB. For each slot it sees the destination register, a write-enable and a load flag. It also sees three consumer sources:
- the two register operands of the instruction in EX1. These feed the ALU and the branch-condition test, and the second one also carries store data.
- the store-data register of the instruction in MEM1.

For each consumer it returns a 2-bit code that drives the matching datapath multiplexer.

The block has no streaming data path. All pins are plain control signals that are valid in the same cycle, with no handshake and no back-pressure. Stalling on results that are not yet ready is left to a separate hazard unit.

Top module: `operand_bypass_sel`

## Requirements
- R1: When no producer slot matches a consumer source, that consumer's select is 0 (register-file value). With all inputs at zero, all three selects are 0.
- R2: A producer matches a source only when its write-enable is 1, its destination is nonzero, and its destination equals the source. A source of register 0 always selects 0.
- R3: An EX1 operand whose youngest match is an ALU instruction in MEM1 (two instructions ahead) selects 1, the EX2/MEM1 ALU result.
- R4: An EX1 operand whose youngest match is an ALU instruction in MEM2 (three instructions ahead) selects 3, the MEM1/MEM2 ALU result.
- R5: An EX1 operand whose youngest match is a load in LWB (four instructions ahead) selects 2, the MEM2/LWB load result. An ALU instruction matching in LWB selects 0, because its value is already in the register file.
- R6: When several slots match the same source, the youngest decides, in the order MEM1, then MEM2, then LWB.
- R7: If the youngest match is a load in MEM1 or MEM2, its data is not yet ready, so the select is 0 even when an older slot also matches.
- R8: The two EX1 operands are resolved independently, with the same table. The second operand serves both ALU input B and store data, so a store four instructions after a load gets its data through code 2.
- R9: The MEM1 store-data select is 3 when an ALU instruction in MEM2 writes the store-data source. It is 0 when that MEM2 instruction is a load or does not match. The MEM1 and LWB slots never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem1_dest | input | AW | Destination register of the instruction in MEM1 |
| mem1_wen | input | 1 | That instruction writes a register |
| mem1_load | input | 1 | That instruction is a load |
| mem2_dest | input | AW | Destination register of the instruction in MEM2 |
| mem2_wen | input | 1 | That instruction writes a register |
| mem2_load | input | 1 | That instruction is a load |
| lwb_dest | input | AW | Destination register of the instruction in LWB |
| lwb_wen | input | 1 | That instruction writes a register |
| lwb_load | input | 1 | That instruction is a load |
| ex1_rs1 | input | AW | First source of the EX1 instruction (ALU A, branch test) |
| ex1_rs2 | input | AW | Second source of the EX1 instruction (ALU B, store data) |
| mem1_st_src | input | AW | Store-data source of the instruction in MEM1 |
| ex1_sel_a | output | 2 | Bypass select for EX1 operand A |
| ex1_sel_b | output | 2 | Bypass select for EX1 operand B |
| mem1_sel_st | output | 2 | Bypass select for MEM1 store data |

## Verification
The immediate assertions are evaluated whenever the inputs change. They check that a source of register 0 and a source with no match both select the register file. They check that each nonzero code points back to a slot of the right class holding the right register, with no younger match ahead of it. They also check that the store-data select never uses a code that belongs only to EX1.

Other behaviours only appear when particular slot combinations are driven:
- an unready youngest load hiding a ready older producer
- an ALU result in LWB falling back to the register file
- both EX1 operands resolving to different slots at once

The bench's directed cases and its random mix, which is concentrated on a few register numbers, cover these.

// File: rtl/byp_pkg.sv
package byp_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF       = 2'd0,
    SEL_MEM1_ALU = 2'd1,
    SEL_LWB_LOAD = 2'd2,
    SEL_MEM2_ALU = 2'd3
  } byp_sel_e;

endpackage

// File: rtl/byp_hit.sv
module byp_hit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dest,
  input  logic          wen,
  output logic          hit
);

  // a producer counts only if it writes a real register
  assign hit = wen && (dest != '0) && (dest == src);

endmodule

// File: rtl/byp_pick.sv
module byp_pick
  import byp_pkg::*;
#(
  parameter int AW    = 5,
  parameter int NPROD = 3,
  // per-slot code for an ALU producer and for a load producer; slot 0 is youngest
  parameter logic [NPROD-1:0][SEL_W-1:0] ALU_CODE  = {2'd0, 2'd3, 2'd1},
  parameter logic [NPROD-1:0][SEL_W-1:0] LOAD_CODE = {2'd2, 2'd0, 2'd0}
) (
  input  logic [AW-1:0]            src,
  input  logic [NPROD-1:0][AW-1:0] dest,
  input  logic [NPROD-1:0]         wen,
  input  logic [NPROD-1:0]         is_load,
  output byp_sel_e                 sel
);

  logic [NPROD-1:0] hit;

  for (genvar g = 0; g < NPROD; g++) begin : g_slot
    byp_hit #(.AW(AW)) i_hit (
      .src  (src),
      .dest (dest[g]),
      .wen  (wen[g]),
      .hit  (hit[g])
    );
  end

  // oldest first, so the youngest matching slot is written last and wins
  always_comb begin
    sel = SEL_RF;
    for (int i = NPROD - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel = is_load[i] ? byp_sel_e'(LOAD_CODE[i]) : byp_sel_e'(ALU_CODE[i]);
      end
    end
  end

  always_comb begin
    AST_SRC_ZERO_RF: assert (src != '0 || sel == SEL_RF)
      else $error("register 0 was bypassed"); // R2
  end

  logic any_raw_match;
  always_comb begin
    any_raw_match = 1'b0;
    for (int i = 0; i < NPROD; i++) begin
      any_raw_match = any_raw_match | (wen[i] && dest[i] == src);
    end
  end

  always_comb begin
    AST_NO_MATCH_RF: assert (any_raw_match || sel == SEL_RF)
      else $error("bypass chosen without a writing producer"); // R1
  end

endmodule

// File: rtl/operand_bypass_sel.sv
module operand_bypass_sel
  import byp_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0]    mem1_dest,
  input  logic             mem1_wen,
  input  logic             mem1_load,
  input  logic [AW-1:0]    mem2_dest,
  input  logic             mem2_wen,
  input  logic             mem2_load,
  input  logic [AW-1:0]    lwb_dest,
  input  logic             lwb_wen,
  input  logic             lwb_load,
  input  logic [AW-1:0]    ex1_rs1,
  input  logic [AW-1:0]    ex1_rs2,
  input  logic [AW-1:0]    mem1_st_src,
  output logic [SEL_W-1:0] ex1_sel_a,
  output logic [SEL_W-1:0] ex1_sel_b,
  output logic [SEL_W-1:0] mem1_sel_st
);

  localparam int NPROD  = 3;
  localparam int NEX1OP = 2;

  // slot order: 0 = MEM1 (youngest), 1 = MEM2, 2 = LWB
  logic [NPROD-1:0][AW-1:0] slot_dest;
  logic [NPROD-1:0]         slot_wen;
  logic [NPROD-1:0]         slot_load;

  assign slot_dest = {lwb_dest, mem2_dest, mem1_dest};
  assign slot_wen  = {lwb_wen,  mem2_wen,  mem1_wen};
  assign slot_load = {lwb_load, mem2_load, mem1_load};

  logic [NEX1OP-1:0][AW-1:0] ex1_src;
  byp_sel_e                  ex1_sel [NEX1OP];

  assign ex1_src = {ex1_rs2, ex1_rs1};

  for (genvar op = 0; op < NEX1OP; op++) begin : g_ex1_op
    byp_pick #(
      .AW        (AW),
      .NPROD     (NPROD),
      .ALU_CODE  ({SEL_RF,       SEL_MEM2_ALU, SEL_MEM1_ALU}),
      .LOAD_CODE ({SEL_LWB_LOAD, SEL_RF,       SEL_RF})
    ) i_pick (
      .src     (ex1_src[op]),
      .dest    (slot_dest),
      .wen     (slot_wen),
      .is_load (slot_load),
      .sel     (ex1_sel[op])
    );
  end

  assign ex1_sel_a = ex1_sel[0];
  assign ex1_sel_b = ex1_sel[1];

  // store data in MEM1 only sees the instruction directly ahead, now in MEM2
  byp_sel_e st_sel;

  byp_pick #(
    .AW        (AW),
    .NPROD     (1),
    .ALU_CODE  ({SEL_MEM2_ALU}),
    .LOAD_CODE ({SEL_RF})
  ) i_store_pick (
    .src     (mem1_st_src),
    .dest    (mem2_dest),
    .wen     (mem2_wen),
    .is_load (mem2_load),
    .sel     (st_sel)
  );

  assign mem1_sel_st = st_sel;

  logic m1_a, m2_a;
  assign m1_a = mem1_wen && mem1_dest == ex1_rs1;
  assign m2_a = mem2_wen && mem2_dest == ex1_rs1;

  always_comb begin
    AST_MEM1_ALU_SRC: assert (ex1_sel_a != SEL_MEM1_ALU || (m1_a && !mem1_load))
      else $error("code 1 without ALU producer in MEM1"); // R3
    AST_MEM2_ALU_SRC: assert (ex1_sel_a != SEL_MEM2_ALU || (m2_a && !mem2_load && !m1_a))
      else $error("code 3 without youngest ALU producer in MEM2"); // R4
    AST_LWB_LOAD_SRC: assert (ex1_sel_a != SEL_LWB_LOAD ||
                              (lwb_wen && lwb_load && lwb_dest == ex1_rs1 && !m1_a && !m2_a))
      else $error("code 2 without youngest load in LWB"); // R5
    AST_STORE_CODES: assert (mem1_sel_st == SEL_RF || mem1_sel_st == SEL_MEM2_ALU)
      else $error("store data used an EX1-only code"); // R9
  end

endmodule

// File: tb/test_operand_bypass_sel.sv
module test_operand_bypass_sel;

  localparam int AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] mem1_dest, mem2_dest, lwb_dest, ex1_rs1, ex1_rs2, mem1_st_src;
  logic mem1_wen, mem1_load, mem2_wen, mem2_load, lwb_wen, lwb_load;
  logic [1:0] ex1_sel_a, ex1_sel_b, mem1_sel_st;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  operand_bypass_sel #(.AW(AW)) i_operand_bypass_sel (
    .mem1_dest, .mem1_wen, .mem1_load,
    .mem2_dest, .mem2_wen, .mem2_load,
    .lwb_dest,  .lwb_wen,  .lwb_load,
    .ex1_rs1, .ex1_rs2, .mem1_st_src,
    .ex1_sel_a, .ex1_sel_b, .mem1_sel_st
  );

  // expected EX1 code from R1..R7
  function automatic int ex1_ref(input logic [AW-1:0] s);
    if (s == 0) return 0;
    if (mem1_wen && mem1_dest == s) return mem1_load ? 0 : 1;
    if (mem2_wen && mem2_dest == s) return mem2_load ? 0 : 3;
    if (lwb_wen  && lwb_dest  == s) return lwb_load  ? 2 : 0;
    return 0;
  endfunction

  // expected store-data code from R9
  function automatic int st_ref(input logic [AW-1:0] s);
    if (s != 0 && mem2_wen && mem2_dest == s && !mem2_load) return 3;
    return 0;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic clear();
    {mem1_dest, mem2_dest, lwb_dest, ex1_rs1, ex1_rs2, mem1_st_src} = '0;
    {mem1_wen, mem1_load, mem2_wen, mem2_load, lwb_wen, lwb_load} = '0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic check_all(input string req);
    chk({req, " sel_a"}, int'(ex1_sel_a), ex1_ref(ex1_rs1));
    chk({req, " sel_b"}, int'(ex1_sel_b), ex1_ref(ex1_rs2));
    chk({req, " sel_st"}, int'(mem1_sel_st), st_ref(mem1_st_src));
  endtask

  initial begin
    clear();
    @(negedge clk); settle();
    chk("R1 idle a", int'(ex1_sel_a), 0);
    chk("R1 idle b", int'(ex1_sel_b), 0);
    chk("R1 idle st", int'(mem1_sel_st), 0);

    // R3: ALU two ahead
    @(negedge clk); clear(); mem1_dest = 5; mem1_wen = 1; ex1_rs1 = 5; ex1_rs2 = 7; settle();
    chk("R3 mem1 alu", int'(ex1_sel_a), 1);
    chk("R8 other operand", int'(ex1_sel_b), 0);
    // R2: write-enable low
    mem1_wen = 0; settle();
    chk("R2 wen low", int'(ex1_sel_a), 0);
    // R2: register 0
    @(negedge clk); clear(); mem1_wen = 1; mem2_wen = 1; lwb_wen = 1; lwb_load = 1; mem1_st_src = 0; settle();
    chk("R2 reg0 a", int'(ex1_sel_a), 0);
    chk("R2 reg0 st", int'(mem1_sel_st), 0);
    // R4 / R7
    @(negedge clk); clear(); mem2_dest = 9; mem2_wen = 1; ex1_rs1 = 9; settle();
    chk("R4 mem2 alu", int'(ex1_sel_a), 3);
    mem2_load = 1; settle();
    chk("R7 mem2 load", int'(ex1_sel_a), 0);
    // R5
    @(negedge clk); clear(); lwb_dest = 3; lwb_wen = 1; lwb_load = 1; ex1_rs2 = 3; settle();
    chk("R5 lwb load", int'(ex1_sel_b), 2);
    lwb_load = 0; settle();
    chk("R5 lwb alu", int'(ex1_sel_b), 0);
    // R6: priority
    @(negedge clk); clear();
    mem1_dest = 4; mem2_dest = 4; lwb_dest = 4; mem1_wen = 1; mem2_wen = 1; lwb_wen = 1; lwb_load = 1;
    ex1_rs1 = 4; settle();
    chk("R6 mem1 first", int'(ex1_sel_a), 1);
    mem1_wen = 0; settle();
    chk("R6 mem2 over lwb", int'(ex1_sel_a), 3);
    // R7: unready youngest hides ready older
    @(negedge clk); clear(); mem1_dest = 6; mem1_wen = 1; mem1_load = 1;
    lwb_dest = 6; lwb_wen = 1; lwb_load = 1; ex1_rs1 = 6; settle();
    chk("R7 mem1 load hides lwb", int'(ex1_sel_a), 0);
    // R8: independent operands
    @(negedge clk); clear(); mem1_dest = 1; mem1_wen = 1; lwb_dest = 2; lwb_wen = 1; lwb_load = 1;
    ex1_rs1 = 1; ex1_rs2 = 2; settle();
    chk("R8 a", int'(ex1_sel_a), 1);
    chk("R8 b load-store", int'(ex1_sel_b), 2);
    // R9: store data
    @(negedge clk); clear(); mem2_dest = 12; mem2_wen = 1; mem1_st_src = 12; settle();
    chk("R9 store alu", int'(mem1_sel_st), 3);
    mem2_load = 1; settle();
    chk("R9 store load", int'(mem1_sel_st), 0);
    @(negedge clk); clear(); mem1_dest = 12; mem1_wen = 1; lwb_dest = 12; lwb_wen = 1; lwb_load = 1;
    mem1_st_src = 12; settle();
    chk("R9 store ignores mem1 lwb", int'(mem1_sel_st), 0);

    // random mix over a few registers (R1..R9)
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      mem1_dest = AW'($urandom_range(0, 3)); mem1_wen = 1'($urandom); mem1_load = 1'($urandom);
      mem2_dest = AW'($urandom_range(0, 3)); mem2_wen = 1'($urandom); mem2_load = 1'($urandom);
      lwb_dest  = AW'($urandom_range(0, 3)); lwb_wen  = 1'($urandom); lwb_load  = 1'($urandom);
      ex1_rs1 = AW'($urandom_range(0, 3)); ex1_rs2 = AW'($urandom_range(0, 3));
      mem1_st_src = AW'($urandom_range(0, 3));
      settle();
      check_all("R6 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule